// File: doc/BRIEF.md
# Raw Pixel Black Offset, Digital Gain and Offset Restore Stage

This block conditions a raw 10-bit image stream at the head of a camera pipeline. A programmable black offset is taken off every incoming pixel so that the sensor's black floor lands on code zero. The result is then multiplied by an unsigned fixed-point digital gain between ×1 and ×8, which lifts dim scenes. Under register control, a built-in pattern source can take the place of the gained pixels: a flat field, eight vertical bars, or a diagonal ramp.

A second, independent path sits after an external shading-correction block. It adds a programmable offset back onto the corrected stream, and that offset defaults to zero. Each path latches its own settings on its own start-of-frame pixel, so no frame ever carries a mix of two configurations. Valid, start-of-line and start-of-frame markers travel with the data through every register stage.

Top module: `pix_front_cond`

## Requirements
- R1: On the main path each valid pixel leaves as max(pixel − black_offset, 0) before gain, two clock cycles after it enters.
- R2: Gain is unsigned 3.5 fixed point (0x20 is ×1, 0xFF is about ×7.97). The main output is (diff × gain + 16) >> 5, which rounds to nearest, limited to 1023.
- R3: A gain code below 0x20 acts as exactly ×1.
- R4: Pattern select code 0 passes live data. Code 1 outputs the flat level register. Code 2 outputs bar k × 146, where k = min(x / (LINE_W/8), 7). Code 3 outputs (x + y) mod 1024. Here x counts valid pixels since the last start-of-line, starting at 0. y counts lines since start-of-frame, starting at 0.
- R5: Main-path settings (offset, gain, pattern select, flat level) are captured on a valid start-of-frame pixel, and that pixel already uses them. Changes at any other time have no effect until the next valid start-of-frame.
- R6: The valid, start-of-line and start-of-frame markers appear at the outputs delayed by exactly the data latency: two cycles on the main path and one on the post path.
- R7: The post path outputs min(shd_data + add_offset, 1023) one cycle after each valid pixel.
- R8: The post-path offset is captured only on a valid post-path start-of-frame, independently of the main path.
- R9: After reset all outputs are zero. Until the first start-of-frame the settings are offset 0, gain ×1, live data and add offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_vld_i | input | 1 | Raw pixel valid |
| pix_sol_i | input | 1 | Raw pixel is first of a line |
| pix_sof_i | input | 1 | Raw pixel is first of a frame |
| pix_data_i | input | 10 | Raw pixel value |
| blk_sub_i | input | 10 | Black offset to subtract |
| gain_i | input | 8 | Digital gain, 3.5 fixed point |
| tp_sel_i | input | 2 | Pattern select (0 live, 1 flat, 2 bars, 3 ramp) |
| tp_lvl_i | input | 10 | Flat-field level |
| blk_add_i | input | 10 | Offset added on post path |
| cond_vld_o | output | 1 | Main output valid |
| cond_sol_o | output | 1 | Main output start-of-line |
| cond_sof_o | output | 1 | Main output start-of-frame |
| cond_data_o | output | 10 | Main output pixel |
| shd_vld_i | input | 1 | Shading-corrected pixel valid |
| shd_sol_i | input | 1 | Shading-corrected start-of-line |
| shd_sof_i | input | 1 | Shading-corrected start-of-frame |
| shd_data_i | input | 10 | Shading-corrected pixel |
| post_vld_o | output | 1 | Post output valid |
| post_sol_o | output | 1 | Post output start-of-line |
| post_sof_o | output | 1 | Post output start-of-frame |
| post_data_o | output | 10 | Post output pixel |

## Verification
The assertions assume that reset drives every input to zero, and that start-of-frame and start-of-line are only raised on a valid pixel, with start-of-frame always paired with start-of-line. The stimulus keeps to this: it drives markers only on the first valid pixel of a line, and idle cycles carry all-zero markers. Settings are changed freely in the middle of frames, because the hold property relies on nothing more than the start-of-frame qualifier. Sweeps then confirm that such changes show up only from the next frame onward.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;
  typedef enum logic [1:0] {
    TP_LIVE = 2'd0,
    TP_FLAT = 2'd1,
    TP_BARS = 2'd2,
    TP_RAMP = 2'd3
  } tp_sel_e;

  typedef struct packed {
    logic vld;
    logic sol;
    logic sof;
  } mark_t;
endpackage

// File: rtl/pc_shadow.sv
`timescale 1ns/1ps
// Frame-synchronous setting holder; eff_o already reflects d_i on the load cycle.
module pc_shadow #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= RST;
    else if (load_i) q <= d_i;
  end

  assign eff_o = load_i ? d_i : q;
endmodule

// File: rtl/pc_pos_tpg.sv
`timescale 1ns/1ps
module pc_pos_tpg
  import pc_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int CNT_W  = 12,
  parameter int LINE_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mark_t            mark_i,
  input  tp_sel_e          sel_i,
  input  logic [PIX_W-1:0] lvl_i,
  output logic [PIX_W-1:0] pat_o
);
  localparam int BAR_N    = 8;
  localparam int BAR_W    = (LINE_W / BAR_N) < 1 ? 1 : LINE_W / BAR_N;
  localparam int BAR_STEP = ((1 << PIX_W) - 1) / (BAR_N - 1);

  logic [CNT_W-1:0] x_q, y_q, x_cur, y_cur, bar_c, ramp_c;
  logic [2:0]       bar_idx;

  always_comb begin
    x_cur = mark_i.sol ? '0 : x_q;
    if (mark_i.sof)      y_cur = '0;
    else if (mark_i.sol) y_cur = y_q + CNT_W'(1);
    else                 y_cur = y_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (mark_i.vld) begin
      x_q <= x_cur + CNT_W'(1);
      y_q <= y_cur;
    end
  end

  always_comb begin
    bar_c   = x_cur / CNT_W'(BAR_W);
    bar_idx = (bar_c > CNT_W'(BAR_N - 1)) ? 3'(BAR_N - 1) : bar_c[2:0];
    ramp_c  = x_cur + y_cur;
    unique case (sel_i)
      TP_FLAT: pat_o = lvl_i;
      TP_BARS: pat_o = PIX_W'(int'(bar_idx) * BAR_STEP);
      TP_RAMP: pat_o = ramp_c[PIX_W-1:0];
      default: pat_o = '0;
    endcase
  end
endmodule

// File: rtl/pc_main_pipe.sv
`timescale 1ns/1ps
// Stage 1: offset subtract; stage 2: rounded gain and pattern mux.
module pc_main_pipe
  import pc_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mark_t             mark_i,
  input  logic [PIX_W-1:0]  data_i,
  input  logic [PIX_W-1:0]  blk_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  tp_sel_e           sel_i,
  input  logic [PIX_W-1:0]  pat_i,
  output mark_t             mark_o,
  output logic [PIX_W-1:0]  data_o
);
  localparam int PW = PIX_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] ONE  = GAIN_W'(1 << GAIN_FRAC);
  localparam logic [PW-1:0]     HALF = PW'(1 << (GAIN_FRAC - 1));
  localparam logic [PW-1:0]     MAXV = PW'((1 << PIX_W) - 1);

  mark_t             m1;
  logic [PIX_W-1:0]  sub1, pat1, sub_c, res_c;
  logic [GAIN_W-1:0] gain1, g_eff;
  tp_sel_e           sel1;
  logic [PW-1:0]     prod, scaled;

  assign sub_c = (data_i > blk_i) ? data_i - blk_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1    <= '0;
      sub1  <= '0;
      pat1  <= '0;
      gain1 <= ONE;
      sel1  <= TP_LIVE;
    end else begin
      m1    <= mark_i;
      sub1  <= sub_c;
      pat1  <= pat_i;
      gain1 <= gain_i;
      sel1  <= sel_i;
    end
  end

  always_comb begin
    g_eff  = (gain1 < ONE) ? ONE : gain1;
    prod   = PW'(sub1) * PW'(g_eff);
    scaled = (prod + HALF) >> GAIN_FRAC;
    res_c  = (scaled > MAXV) ? MAXV[PIX_W-1:0] : scaled[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mark_o <= '0;
      data_o <= '0;
    end else begin
      mark_o <= m1;
      data_o <= (sel1 == TP_LIVE) ? res_c : pat1;
    end
  end
endmodule

// File: rtl/pc_blk_add.sv
`timescale 1ns/1ps
module pc_blk_add
  import pc_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mark_t            mark_i,
  input  logic [PIX_W-1:0] data_i,
  input  logic [PIX_W-1:0] lvl_i,
  output mark_t            mark_o,
  output logic [PIX_W-1:0] data_o
);
  logic [PIX_W:0] sum_c;

  assign sum_c = {1'b0, data_i} + {1'b0, lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mark_o <= '0;
      data_o <= '0;
    end else begin
      mark_o <= mark_i;
      data_o <= sum_c[PIX_W] ? '1 : sum_c[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/pix_front_cond.sv
`timescale 1ns/1ps
module pix_front_cond
  import pc_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int CNT_W     = 12,
  parameter int LINE_W    = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_vld_i,
  input  logic              pix_sol_i,
  input  logic              pix_sof_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic [PIX_W-1:0]  blk_sub_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [1:0]        tp_sel_i,
  input  logic [PIX_W-1:0]  tp_lvl_i,
  input  logic [PIX_W-1:0]  blk_add_i,
  output logic              cond_vld_o,
  output logic              cond_sol_o,
  output logic              cond_sof_o,
  output logic [PIX_W-1:0]  cond_data_o,
  input  logic              shd_vld_i,
  input  logic              shd_sol_i,
  input  logic              shd_sof_i,
  input  logic [PIX_W-1:0]  shd_data_i,
  output logic              post_vld_o,
  output logic              post_sol_o,
  output logic              post_sof_o,
  output logic [PIX_W-1:0]  post_data_o
);
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1 << GAIN_FRAC);

  logic              ld_main, ld_post;
  logic [PIX_W-1:0]  blk_sub_eff, tp_lvl_eff, blk_add_eff, pat;
  logic [GAIN_W-1:0] gain_eff;
  logic [1:0]        sel_eff;
  mark_t             mark_in, shd_mark, cond_mark, post_mark;

  assign ld_main  = pix_vld_i & pix_sof_i;
  assign ld_post  = shd_vld_i & shd_sof_i;
  assign mark_in  = '{vld: pix_vld_i, sol: pix_sol_i, sof: pix_sof_i};
  assign shd_mark = '{vld: shd_vld_i, sol: shd_sol_i, sof: shd_sof_i};

  pc_shadow #(.W(PIX_W))  i_sh_blk (.clk_i, .rst_ni, .load_i(ld_main), .d_i(blk_sub_i), .eff_o(blk_sub_eff));
  pc_shadow #(.W(GAIN_W), .RST(GAIN_ONE))
                          i_sh_gain(.clk_i, .rst_ni, .load_i(ld_main), .d_i(gain_i),    .eff_o(gain_eff));
  pc_shadow #(.W(2))      i_sh_sel (.clk_i, .rst_ni, .load_i(ld_main), .d_i(tp_sel_i),  .eff_o(sel_eff));
  pc_shadow #(.W(PIX_W))  i_sh_lvl (.clk_i, .rst_ni, .load_i(ld_main), .d_i(tp_lvl_i),  .eff_o(tp_lvl_eff));
  pc_shadow #(.W(PIX_W))  i_sh_add (.clk_i, .rst_ni, .load_i(ld_post), .d_i(blk_add_i), .eff_o(blk_add_eff));

  pc_pos_tpg #(.PIX_W(PIX_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) i_tpg (
    .clk_i, .rst_ni, .mark_i(mark_in), .sel_i(tp_sel_e'(sel_eff)),
    .lvl_i(tp_lvl_eff), .pat_o(pat)
  );

  pc_main_pipe #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) i_main (
    .clk_i, .rst_ni, .mark_i(mark_in), .data_i(pix_data_i), .blk_i(blk_sub_eff),
    .gain_i(gain_eff), .sel_i(tp_sel_e'(sel_eff)), .pat_i(pat),
    .mark_o(cond_mark), .data_o(cond_data_o)
  );

  pc_blk_add #(.PIX_W(PIX_W)) i_add (
    .clk_i, .rst_ni, .mark_i(shd_mark), .data_i(shd_data_i), .lvl_i(blk_add_eff),
    .mark_o(post_mark), .data_o(post_data_o)
  );

  assign cond_vld_o = cond_mark.vld;
  assign cond_sol_o = cond_mark.sol;
  assign cond_sof_o = cond_mark.sof;
  assign post_vld_o = post_mark.vld;
  assign post_sol_o = post_mark.sol;
  assign post_sof_o = post_mark.sof;
endmodule

// File: rtl/pc_front_chk.sv
`timescale 1ns/1ps
module pc_front_chk #(
  parameter int PIX_W = 10,
  parameter int CFG_W = 30
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_vld_i,
  input logic             pix_sol_i,
  input logic             pix_sof_i,
  input logic             cond_vld_o,
  input logic             cond_sol_o,
  input logic             cond_sof_o,
  input logic             shd_vld_i,
  input logic             shd_sol_i,
  input logic             shd_sof_i,
  input logic [PIX_W-1:0] shd_data_i,
  input logic             post_vld_o,
  input logic             post_sol_o,
  input logic             post_sof_o,
  input logic [PIX_W-1:0] post_data_o,
  input logic [CFG_W-1:0] cfg_main,
  input logic [PIX_W-1:0] cfg_post
);
  logic [1:0] age_q;
  logic       armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign armed = (age_q == 2'd3);

  // R6
  mark_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (cond_vld_o == $past(pix_vld_i, 2) && cond_sol_o == $past(pix_sol_i, 2)
               && cond_sof_o == $past(pix_sof_i, 2)));

  // R6
  mark_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (post_vld_o == $past(shd_vld_i) && post_sol_o == $past(shd_sol_i)
               && post_sof_o == $past(shd_sof_i)));

  // R7
  post_no_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(shd_vld_i)) |-> (post_data_o >= $past(shd_data_i)));

  // R5
  main_cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !(pix_vld_i && pix_sof_i)) |-> $stable(cfg_main));

  // R8
  post_cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !(shd_vld_i && shd_sof_i)) |-> $stable(cfg_post));
endmodule

bind pix_front_cond pc_front_chk #(.PIX_W(PIX_W), .CFG_W(3 * PIX_W + GAIN_W + 2)) i_front_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .pix_vld_i(pix_vld_i), .pix_sol_i(pix_sol_i), .pix_sof_i(pix_sof_i),
  .cond_vld_o(cond_vld_o), .cond_sol_o(cond_sol_o), .cond_sof_o(cond_sof_o),
  .shd_vld_i(shd_vld_i), .shd_sol_i(shd_sol_i), .shd_sof_i(shd_sof_i), .shd_data_i(shd_data_i),
  .post_vld_o(post_vld_o), .post_sol_o(post_sol_o), .post_sof_o(post_sof_o), .post_data_o(post_data_o),
  .cfg_main({blk_sub_eff, gain_eff, sel_eff, tp_lvl_eff}),
  .cfg_post(blk_add_eff)
);

// File: tb/test_pix_front_cond.sv
`timescale 1ns/1ps
module test_pix_front_cond;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pv = 0, pl = 0, pf = 0, sv = 0, sl = 0, sf = 0;
  logic [9:0] pd = '0, sd = '0;
  logic [9:0] c_blk = '0, c_lvl = '0, c_add = '0;
  logic [7:0] c_gain = 8'h20;
  logic [1:0] c_sel = '0;
  logic       cond_vld_o, cond_sol_o, cond_sof_o, post_vld_o, post_sol_o, post_sof_o;
  logic [9:0] cond_data_o, post_data_o;

  int checks = 0, fails = 0, cyc = 0, pcnt = 0;
  int m_blk = 0, m_gain = 32, m_sel = 0, m_lvl = 0, m_add = 0, m_x = 0, m_y = 0;
  string main_tag = "R1", add_tag = "R7";
  logic [2:0] rm_mark[4], ra_mark[4];
  int         rm_data[4], ra_data[4];
  string      rm_tag[4], ra_tag[4];

  always #2.5 clk = ~clk;

  pix_front_cond i_pix_front_cond (
    .clk_i(clk), .rst_ni(rst_n),
    .pix_vld_i(pv), .pix_sol_i(pl), .pix_sof_i(pf), .pix_data_i(pd),
    .blk_sub_i(c_blk), .gain_i(c_gain), .tp_sel_i(c_sel), .tp_lvl_i(c_lvl), .blk_add_i(c_add),
    .cond_vld_o(cond_vld_o), .cond_sol_o(cond_sol_o), .cond_sof_o(cond_sof_o), .cond_data_o(cond_data_o),
    .shd_vld_i(sv), .shd_sol_i(sl), .shd_sof_i(sf), .shd_data_i(sd),
    .post_vld_o(post_vld_o), .post_sol_o(post_sol_o), .post_sof_o(post_sof_o), .post_data_o(post_data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_main(int d, int x, int y);
    int s, g, p;
    case (m_sel)
      1: return m_lvl;
      2: begin p = x / 8; if (p > 7) p = 7; return p * 146; end
      3: return (x + y) % 1024;
      default: begin
        s = (d > m_blk) ? d - m_blk : 0;
        g = (m_gain < 32) ? 32 : m_gain;
        p = (s * g + 16) / 32;
        return (p > 1023) ? 1023 : p;
      end
    endcase
  endfunction

  task automatic step(input logic v, input logic l, input logic f, input int d);
    int k, xc, yc, s;
    if (cyc >= 2) begin
      k = (cyc - 2) % 4;
      chk("R6 main markers", {29'd0, cond_vld_o, cond_sol_o, cond_sof_o}, {29'd0, rm_mark[k]});
      if (rm_mark[k][2]) chk(rm_tag[k], {22'd0, cond_data_o}, rm_data[k]);
    end
    if (cyc >= 1) begin
      k = (cyc - 1) % 4;
      chk("R6 post markers", {29'd0, post_vld_o, post_sol_o, post_sof_o}, {29'd0, ra_mark[k]});
      if (ra_mark[k][2]) chk(ra_tag[k], {22'd0, post_data_o}, ra_data[k]);
    end
    k = cyc % 4;
    s = (d * 37 + 11) % 1024;
    rm_mark[k] = {v, l, f};
    ra_mark[k] = {v, l, f};
    rm_tag[k] = main_tag;
    ra_tag[k] = add_tag;
    rm_data[k] = 0;
    ra_data[k] = 0;
    if (v) begin
      if (f) begin
        m_blk = int'(c_blk); m_gain = int'(c_gain); m_sel = int'(c_sel);
        m_lvl = int'(c_lvl); m_add = int'(c_add);
      end
      xc = l ? 0 : m_x;
      yc = f ? 0 : (l ? m_y + 1 : m_y);
      m_x = xc + 1;
      m_y = yc;
      rm_data[k] = exp_main(d, xc, yc);
      ra_data[k] = (s + m_add > 1023) ? 1023 : s + m_add;
    end
    pv = v; pl = l; pf = f; pd = 10'(d);
    sv = v; sl = l; sf = f; sd = 10'(s);
    @(negedge clk);
    cyc++;
  endtask

  function automatic int dat(int kind, int i);
    if (kind == 1) return (i == 15) ? 1023 : i * 68;
    return pcnt % 1024;
  endfunction

  task automatic line(input bit first, input int px, input int kind, input int gap);
    for (int i = 0; i < px; i++) begin
      if (gap > 0 && i > 0 && i % gap == 0) step(0, 0, 0, 0);
      step(1, i == 0, first && i == 0, dat(kind, i));
      pcnt++;
    end
    step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs cleared in reset
    chk("R9 reset cond_vld", {31'd0, cond_vld_o}, 0);
    chk("R9 reset cond_data", {22'd0, cond_data_o}, 0);
    chk("R9 reset post_vld", {31'd0, post_vld_o}, 0);
    chk("R9 reset post_data", {22'd0, post_data_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: defaults hold until first start-of-frame, inputs ignored
    main_tag = "R9"; add_tag = "R9";
    c_blk = 10'd50; c_gain = 8'd64; c_sel = 2'd3; c_add = 10'd9;
    line(0, 20, 0, 3);

    // R1: offset subtract over all 1024 codes at unity gain
    main_tag = "R1"; add_tag = "R7";
    c_blk = 10'd100; c_gain = 8'h20; c_sel = 2'd0; c_add = 10'd0;
    pcnt = 0;
    for (int ln = 0; ln < 16; ln++) line(ln == 0, 64, 0, (ln % 3 == 0) ? 7 : 0);

    // R2 / R3: full gain sweep with saturation; R7 add sweep
    for (int g = 0; g < 256; g++) begin
      main_tag = (g < 32) ? "R3" : "R2";
      add_tag = "R7";
      c_gain = 8'(g); c_blk = 10'(g % 8); c_add = 10'(g * 4);
      line(1, 16, 1, 0);
    end

    // R4: pattern sources
    main_tag = "R4";
    c_gain = 8'h20; c_blk = '0; c_add = '0;
    for (int sel = 1; sel < 4; sel++) begin
      c_sel = 2'(sel); c_lvl = 10'd777;
      line(1, 80, 0, 0);
      line(0, 80, 0, 5);
      line(0, 40, 0, 0);
    end

    // R5 / R8: mid-frame changes deferred to the next frame
    main_tag = "R5"; add_tag = "R8";
    c_sel = 2'd0; c_gain = 8'd40; c_blk = 10'd10; c_add = 10'd5;
    line(1, 20, 0, 0);
    c_sel = 2'd2; c_gain = 8'd200; c_blk = 10'd300; c_add = 10'd900;
    line(0, 20, 0, 4);
    line(1, 20, 0, 0);
    c_sel = 2'd0;
    line(0, 20, 0, 0);
    line(1, 30, 0, 0);

    repeat (3) step(0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule